// File: doc/BRIEF.md
# Two-Codeword Interleaved Message Store and Scheduler

This block holds the decoding messages for two codewords at once and sequences one shared group of check-node units and one shared group of bit-node units so that both groups are busy in every cycle of an iteration. The parity-check matrix is viewed as four quadrants, indexed by row half and column half. Each codeword owns a bank of four quadrant registers. A check-node pass works on one row half, which is the quadrant pair in that row. A bit-node pass works on one column half, which is the quadrant pair in that column.

A decode accepts four load beats: codeword 0 column half 0, codeword 0 column half 1, codeword 1 column half 0, and codeword 1 column half 1. It then runs a four-cycle pattern once per iteration. In the first two cycles the check-node side works on codeword 0 and the bit-node side works on codeword 1. In the last two cycles the roles swap. The node arithmetic is outside the block. The block presents a read pair on each side and captures the returned pair at the next clock edge. A one-cycle done pulse follows the last run cycle.

The controller states are ST_IDLE, ST_LD_W0_HI, ST_LD_W1_LO, ST_LD_W1_HI and ST_RUN. Each accepted beat moves the controller one state forward: ST_IDLE to ST_LD_W0_HI, then ST_LD_W1_LO, then ST_LD_W1_HI, then ST_RUN. When the last run cycle finishes, ST_RUN returns to ST_IDLE. Without a beat, a load state holds.

Top module: `dual_cw_msg_sched`

## Requirements
- R1: After reset, ld_ready is 1, cn_act and bn_act are 0, and done is 0.
- R2: Beats are accepted on ld_valid && ld_ready, in the order (cw0,col0), (cw0,col1), (cw1,col0), (cw1,col1). A beat for column c writes ld_data[LW-1:0] to quadrant (row0,c) and ld_data[2LW-1:LW] to quadrant (row1,c), where LW = MSG_W*LANES.
- R3: Idle cycles between beats delay the load without changing its result. The total length grows by one cycle per idle cycle.
- R4: ld_ready is 0 during every run cycle. A request made then changes no stored message.
- R5: Run cycles repeat the phase order 0,1,2,3. In phase p, cn_cw = p[1], bn_cw = !p[1], and cn_half = bn_half = p[0].
- R6: cn_rd is {quadrant(h,1), quadrant(h,0)} of the check-side codeword, where h = cn_half. bn_rd is {quadrant(1,h), quadrant(0,h)} of the bit-side codeword.
- R7: At the end of a run cycle, cn_wr replaces the check-side row pair and bn_wr replaces the bit-side column pair, with the same packing as R6. Nothing else changes, and the two codewords' data never mix.
- R8: max_iter is captured on the first beat, so later changes to it have no effect on that decode. A run lasts 4*max_iter cycles, and a captured value of 0 acts as 1.
- R9: done is high for exactly one cycle, in the cycle after the last run cycle. From the first beat to done, with no gaps, the count is 4+4*max_iter cycles, for example 44 for 10 iterations.
- R10: In every run cycle both cn_act and bn_act are 1, and they serve different codewords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load beat request |
| ld_ready | output | 1 | Load beat can be accepted |
| ld_data | input | 2*LW | Channel values for one column half |
| max_iter | input | ITER_W | Iteration limit, captured on the first beat |
| cn_act | output | 1 | Check-node side active |
| cn_cw | output | 1 | Codeword served by the check-node side |
| cn_half | output | 1 | Row half for the check-node side |
| cn_rd | output | 2*LW | Row pair to the check-node units |
| cn_wr | input | 2*LW | Row pair returned by the check-node units |
| bn_act | output | 1 | Bit-node side active |
| bn_cw | output | 1 | Codeword served by the bit-node side |
| bn_half | output | 1 | Column half for the bit-node side |
| bn_rd | output | 2*LW | Column pair to the bit-node units |
| bn_wr | input | 2*LW | Column pair returned by the bit-node units |
| done | output | 1 | One-cycle pulse after the last run cycle |

## Verification
The bench acts as the two node groups. Each group applies a different codeword-dependent transform, so every read pair in every run cycle can be predicted exactly. Loads are tried with dissimilar data, including all-zero against all-one codewords, so any bleed between banks or quadrants becomes visible in later reads. Iteration limits of 10, 3, 0, 4 and 1 tell correct run lengths apart from off-by-one errors and from the zero case. Beats with gaps, requests during a run, and max_iter changed after the first beat separate correct handshake and capture from a design that drifts in cycle count or takes in stray data.

// File: rtl/dcms_pkg.sv
package dcms_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_W0_HI,
        ST_LD_W1_LO,
        ST_LD_W1_HI,
        ST_RUN
    } sched_state_t;

    localparam int NUM_CW   = 2;
    localparam int NUM_QUAD = 4;
endpackage

// File: rtl/dcms_ctrl.sv
module dcms_ctrl
    import dcms_pkg::*;
#(
    parameter int ITER_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ITER_W-1:0] max_iter,
    output logic              ld_ready,
    output logic              ld_fire,
    output logic              ld_cw,
    output logic              ld_half,
    output logic              run_act,
    output logic [1:0]        phase,
    output logic              done
);
    sched_state_t      state_q, state_d;
    logic [1:0]        phase_q;
    logic [ITER_W-1:0] iter_q, lim_q;
    logic              done_q;
    logic              run_last;

    assign ld_fire  = ld_valid && ld_ready;
    assign run_last = (state_q == ST_RUN) && (phase_q == 2'd3)
                      && (iter_q == ITER_W'(lim_q - 1'b1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (ld_fire) state_d = ST_LD_W0_HI;
            ST_LD_W0_HI: if (ld_fire) state_d = ST_LD_W1_LO;
            ST_LD_W1_LO: if (ld_fire) state_d = ST_LD_W1_HI;
            ST_LD_W1_HI: if (ld_fire) state_d = ST_RUN;
            ST_RUN:      if (run_last) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ld_ready = 1'b1;
        ld_cw    = 1'b0;
        ld_half  = 1'b0;
        run_act  = 1'b0;
        unique case (state_q)
            ST_IDLE:     begin ld_cw = 1'b0; ld_half = 1'b0; end
            ST_LD_W0_HI: begin ld_cw = 1'b0; ld_half = 1'b1; end
            ST_LD_W1_LO: begin ld_cw = 1'b1; ld_half = 1'b0; end
            ST_LD_W1_HI: begin ld_cw = 1'b1; ld_half = 1'b1; end
            ST_RUN:      begin ld_ready = 1'b0; run_act = 1'b1; end
            default:     ld_ready = 1'b1;
        endcase
    end

    // phase, iteration and limit counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
            iter_q  <= '0;
            lim_q   <= ITER_W'(1);
            done_q  <= 1'b0;
        end else begin
            done_q <= run_last;
            if (state_q == ST_IDLE && ld_fire)
                lim_q <= (max_iter == '0) ? ITER_W'(1) : max_iter;
            if (state_q != ST_RUN) begin
                phase_q <= 2'd0;
                iter_q  <= '0;
            end else begin
                phase_q <= phase_q + 2'd1;
                if (phase_q == 2'd3) iter_q <= iter_q + 1'b1;
            end
        end
    end

    assign phase = phase_q;
    assign done  = done_q;

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(run_act) && !run_act));
    assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_act && $past(run_act)) |-> (phase == 2'($past(phase) + 2'd1)));
    assert_load_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_act) |-> ($past(ld_fire) && $past(ld_cw) && $past(ld_half)));
endmodule

// File: rtl/dcms_bank.sv
module dcms_bank
    import dcms_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic          ld_half,
    input  logic [2*LW-1:0] ld_data,
    input  logic          cn_en,
    input  logic          cn_half,
    input  logic [2*LW-1:0] cn_wr,
    input  logic          bn_en,
    input  logic          bn_half,
    input  logic [2*LW-1:0] bn_wr,
    output logic [2*LW-1:0] cn_rd,
    output logic [2*LW-1:0] bn_rd
);
    // quadrant index = row*2 + col
    logic [LW-1:0] quad_q [NUM_QUAD];

    for (genvar g = 0; g < NUM_QUAD; g++) begin : g_quad
        localparam int ROW = g / 2;
        localparam int COL = g % 2;
        always_ff @(posedge clk) begin
            if (!rst_n)
                quad_q[g] <= '0;
            else if (ld_en && (ld_half == COL[0]))
                quad_q[g] <= ld_data[ROW*LW +: LW];
            else if (cn_en && (cn_half == ROW[0]))
                quad_q[g] <= cn_wr[COL*LW +: LW];
            else if (bn_en && (bn_half == COL[0]))
                quad_q[g] <= bn_wr[ROW*LW +: LW];
        end
    end

    assign cn_rd = cn_half ? {quad_q[3], quad_q[2]} : {quad_q[1], quad_q[0]};
    assign bn_rd = bn_half ? {quad_q[3], quad_q[1]} : {quad_q[2], quad_q[0]};

    assert_single_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cn_en |-> (!bn_en && !ld_en));
    assert_load_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bn_en |-> !ld_en);
endmodule

// File: rtl/dual_cw_msg_sched.sv
module dual_cw_msg_sched
    import dcms_pkg::*;
#(
    parameter int MSG_W  = 8,
    parameter int LANES  = 2,
    parameter int ITER_W = 5,
    localparam int LW    = MSG_W * LANES,
    localparam int PW    = 2 * LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    output logic              ld_ready,
    input  logic [PW-1:0]     ld_data,
    input  logic [ITER_W-1:0] max_iter,
    output logic              cn_act,
    output logic              cn_cw,
    output logic              cn_half,
    output logic [PW-1:0]     cn_rd,
    input  logic [PW-1:0]     cn_wr,
    output logic              bn_act,
    output logic              bn_cw,
    output logic              bn_half,
    output logic [PW-1:0]     bn_rd,
    input  logic [PW-1:0]     bn_wr,
    output logic              done
);
    logic       ld_fire, ld_cw, ld_half, run_act;
    logic [1:0] phase;
    logic [PW-1:0] bank_cn_rd [NUM_CW];
    logic [PW-1:0] bank_bn_rd [NUM_CW];

    dcms_ctrl #(.ITER_W(ITER_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .max_iter (max_iter),
        .ld_ready (ld_ready),
        .ld_fire  (ld_fire),
        .ld_cw    (ld_cw),
        .ld_half  (ld_half),
        .run_act  (run_act),
        .phase    (phase),
        .done     (done)
    );

    assign cn_act  = run_act;
    assign bn_act  = run_act;
    assign cn_cw   = run_act &  phase[1];
    assign bn_cw   = run_act & ~phase[1];
    assign cn_half = run_act &  phase[0];
    assign bn_half = run_act &  phase[0];

    for (genvar b = 0; b < NUM_CW; b++) begin : g_bank
        dcms_bank #(.LW(LW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_en   (ld_fire && (ld_cw == b[0])),
            .ld_half (ld_half),
            .ld_data (ld_data),
            .cn_en   (run_act && (cn_cw == b[0])),
            .cn_half (cn_half),
            .cn_wr   (cn_wr),
            .bn_en   (run_act && (bn_cw == b[0])),
            .bn_half (bn_half),
            .bn_wr   (bn_wr),
            .cn_rd   (bank_cn_rd[b]),
            .bn_rd   (bank_bn_rd[b])
        );
    end

    assign cn_rd = bank_cn_rd[cn_cw];
    assign bn_rd = bank_bn_rd[bn_cw];

    assert_split_cw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cn_act |-> (bn_act && (cn_cw != bn_cw)));
    assert_no_load_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cn_act |-> !ld_ready);
endmodule

// File: tb/dual_cw_msg_sched_test.sv
module dual_cw_msg_sched_test;
    localparam int MSG_W = 8, LANES = 2, ITER_W = 5;
    localparam int LW = MSG_W * LANES, PW = 2 * LW;

    typedef struct packed {
        logic cc; logic ch; logic bc; logic bh;
        logic [PW-1:0] cr; logic [PW-1:0] br;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ld_valid = 1'b0;
    logic [PW-1:0] ld_data = '0;
    logic [ITER_W-1:0] max_iter = '0;
    logic ld_ready, cn_act, cn_cw, cn_half, bn_act, bn_cw, bn_half, done;
    logic [PW-1:0] cn_rd, cn_wr, bn_rd, bn_wr;

    function automatic logic [PW-1:0] f_cn(input logic [PW-1:0] x, input logic cw);
        return {x[PW-2:0], x[PW-1]} ^ (cw ? 32'hA5C3_0F1E : 32'h3C3C_1111);
    endfunction
    function automatic logic [PW-1:0] f_bn(input logic [PW-1:0] x, input logic cw);
        return x + (cw ? 32'h0707_0301 : 32'h1020_4081);
    endfunction

    assign cn_wr = f_cn(cn_rd, cn_cw);
    assign bn_wr = f_bn(bn_rd, bn_cw);

    dual_cw_msg_sched #(.MSG_W(MSG_W), .LANES(LANES), .ITER_W(ITER_W)) uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
        .ld_data(ld_data), .max_iter(max_iter),
        .cn_act(cn_act), .cn_cw(cn_cw), .cn_half(cn_half), .cn_rd(cn_rd), .cn_wr(cn_wr),
        .bn_act(bn_act), .bn_cw(bn_cw), .bn_half(bn_half), .bn_rd(bn_rd), .bn_wr(bn_wr),
        .done(done)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0, pairs_seen = 0, pairs_sent = 0;
    bit finished = 1'b0;
    item_t exp_q[$];
    int len_q[$];
    int t0_q[$];
    logic [LW-1:0] mdl [2][4];
    item_t mon_e, mon_a;
    int mon_t0, mon_len;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic load_beat(input int w, input int h, input logic [PW-1:0] d);
        ld_valid = 1'b1;
        ld_data  = d;
        @(posedge clk); #1;
        ld_valid = 1'b0;
        for (int r = 0; r < 2; r++) mdl[w][r*2+h] = d[r*LW +: LW];
    endtask

    // driver side of the scoreboard: expected run-cycle items
    task automatic push_run(input int eff);
        int cw, bw, h;
        item_t e;
        logic [PW-1:0] nc, nb;
        for (int it = 0; it < eff; it++) begin
            for (int p = 0; p < 4; p++) begin
                cw = p / 2; bw = 1 - cw; h = p % 2;
                e.cc = cw[0]; e.ch = h[0]; e.bc = bw[0]; e.bh = h[0];
                e.cr = {mdl[cw][2*h+1], mdl[cw][2*h]};
                e.br = {mdl[bw][2+h], mdl[bw][h]};
                exp_q.push_back(e);
                nc = f_cn(e.cr, e.cc);
                nb = f_bn(e.br, e.bc);
                mdl[cw][2*h]   = nc[LW-1:0];
                mdl[cw][2*h+1] = nc[PW-1:LW];
                mdl[bw][h]     = nb[LW-1:0];
                mdl[bw][2+h]   = nb[PW-1:LW];
            end
        end
    endtask

    task automatic run_pair(input logic [PW-1:0] d0, input logic [PW-1:0] d1,
                            input logic [PW-1:0] d2, input logic [PW-1:0] d3,
                            input int n, input int gap, input bit probe);
        int eff;
        eff = (n == 0) ? 1 : n;
        max_iter = ITER_W'(n);
        t0_q.push_back(cyc);
        len_q.push_back(4 + 4 * eff + 3 * gap);   // R8 R9 R3 expected length
        pairs_sent++;
        load_beat(0, 0, d0);
        max_iter = ITER_W'(n + 7);                // R8: must not matter now
        repeat (gap) begin @(posedge clk); #1; end
        load_beat(0, 1, d1);
        repeat (gap) begin @(posedge clk); #1; end
        load_beat(1, 0, d2);
        repeat (gap) begin @(posedge clk); #1; end
        load_beat(1, 1, d3);
        push_run(eff);
        if (probe) begin
            @(posedge clk); #1;
            for (int k = 0; k < 3; k++) begin
                ld_valid = 1'b1;
                ld_data  = 32'hDEAD_BEEF ^ PW'(k);
                chk(ld_ready == 1'b0, "R4", "ready during run", ld_ready, 0);
                @(posedge clk); #1;
            end
            ld_valid = 1'b0;
        end
        wait (pairs_seen == pairs_sent);
        @(posedge clk); #1;
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (cn_act) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "run cycle beyond limit", 1, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_a = '{cn_cw, cn_half, bn_cw, bn_half, cn_rd, bn_rd};
                    chk(mon_a == mon_e && bn_act, "R5 R6 R7 R10",
                        "run cycle items", mon_a, mon_e);
                end
            end
            if (done) begin
                chk(exp_q.size() == 0, "R9", "run cycles left at done",
                    exp_q.size(), 0);
                if (len_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    mon_t0  = t0_q.pop_front();
                    mon_len = len_q.pop_front();
                    chk(cyc - mon_t0 == mon_len, "R9 R8 R3", "decode length",
                        cyc - mon_t0, mon_len);
                end
                pairs_seen++;
            end
        end
    end

    initial begin
        #(10 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(ld_ready == 1'b1, "R1", "ready after reset", ld_ready, 1);
        chk(cn_act == 1'b0 && bn_act == 1'b0, "R1", "act after reset",
            {cn_act, bn_act}, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        @(posedge clk); #1;

        // R2 R9: ten iterations, contiguous beats, 44 cycles
        run_pair(32'h0102_0304, 32'h1112_1314, 32'hA1A2_A3A4, 32'hB1B2_B3B4, 10, 0, 0);
        // R3: gaps between beats
        run_pair(32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3, 2, 0);
        // R8: zero limit acts as one
        run_pair(32'h5555_AAAA, 32'h0F0F_F0F0, 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 0);
        // R4: requests during run ignored
        run_pair(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 4, 0, 1);
        // R7: single iteration, distinct quadrants
        run_pair(32'h8001_4002, 32'h2004_1008, 32'h0810_0420, 32'h0240_0180, 1, 1, 0);

        repeat (4) @(posedge clk);
        #1;
        chk(pairs_seen == 5, "R9", "done pulses seen", pairs_seen, 5);
        chk(exp_q.size() == 0, "R8", "leftover expected items", exp_q.size(), 0);
        finish_up();
    end
endmodule